// File: doc/BRIEF.md
# Chip-Select Timing Sequencer

This block frames each transaction of a serial flash master in time. It drives the active-low select line and hands the serial shifter a one-cycle start pulse. It counts every delay in reference-clock cycles, not in serial-clock cycles. One 32-bit configuration word holds three 8-bit cycle counts:

- the setup count, from select going low to the first bit;
- the hold count, from the last bit to select going high;
- the gap count, the minimum time select stays high before the next transaction.

The block accepts a transaction when `req` is high and the sequencer is idle. It then:

1. Lowers the select line and waits the setup count.
2. Pulses `xfer_start`.
3. Waits for the shifter to report its final bit on `last_bit_done`.
4. Waits the hold count and raises select.
5. Runs the gap count before it goes idle again.

A request that arrives while the block is busy is not lost. It stays pending with `busy` high and is taken once the gap has expired.

The hold and gap counts are captured when the block accepts the request. The setup count is loaded in the same cycle. Software may therefore rewrite the word during a transaction, and the new values apply only to the next transaction. A typical setting with a 5 ns reference clock is setup 4, hold 4 and gap 36.

Top module: `csel_timing_seq`

## Requirements
- R1: The block pulses `xfer_start` exactly setup cycles after the first cycle in which `sel_n` is low. The setup count is `cfg_word[7:0]`. A value of 0 puts the pulse in that first low cycle.
- R2: `sel_n` returns high hold+1 cycles after the cycle in which `last_bit_done` is high during the active phase. The hold count is `cfg_word[15:8]`. A value of 0 raises select in the next cycle.
- R3: When a request is pending at the end of a transaction, `sel_n` stays high for exactly gap+1 cycles before it falls again. The gap count is `cfg_word[31:24]`, and the extra cycle is the cycle in which the request is accepted. A value of 0 gives one high cycle.
- R4: `xfer_start` is one cycle wide, occurs only while `sel_n` is low, and occurs exactly once per transaction.
- R5: `sel_n` is active low. Out of reset `sel_n` is 1, `busy` is 0 and `xfer_start` is 0, and `busy` is 1 whenever `sel_n` is 0.
- R6: A request raised before the gap has expired is held off: `busy` stays 1 and `sel_n` stays 1 until the gap ends, and the request is then accepted without being raised again. `busy` returns to 0 once the gap has expired and no request is pending.
- R7: The block uses the configuration word as it was in the accept cycle. Changing `cfg_word` later in the same transaction does not alter that transaction's setup, hold or gap.
- R8: Bits `cfg_word[23:16]` have no effect on any timing.
- R9: The block ignores `last_bit_done` outside the active phase. A pulse during setup neither moves the start pulse nor shortens the time select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Setup [7:0], hold [15:8], gap [31:24]; [23:16] unused |
| req | input | 1 | Transaction request, level; accepted when idle |
| last_bit_done | input | 1 | Shifter reports that the final bit has been sent |
| busy | output | 1 | High from accept until the gap has expired |
| sel_n | output | 1 | Active-low flash select |
| xfer_start | output | 1 | One-cycle start pulse to the shifter |

## Verification
A phase register in the wrong state would show at the ports within one cycle, as `sel_n` and `busy` that do not match the transaction in progress. A wrong count or a wrong captured field would appear as a start pulse, select edge or gap length that is off by the error in cycles. The bench measures each of these against the fields it programmed, in the transaction that has the error. A corrupted captured word would surface only at the hold or gap of the same transaction, which is why every transaction rewrites `cfg_word` right after it is accepted.

// File: rtl/csel_seq_pkg.sv
package csel_seq_pkg;

  localparam int CFG_W     = 32;
  localparam int FIELD_W   = 8;
  localparam int SETUP_LSB = 0;
  localparam int HOLD_LSB  = 8;
  localparam int GAP_LSB   = 24;
  localparam int SPARE_LSB = HOLD_LSB + FIELD_W;
  localparam int SPARE_W   = GAP_LSB - SPARE_LSB;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_GAP    = 3'd4
  } phase_t;

  typedef struct packed {
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] gap;
  } tail_t;

  // Extract one delay field from the configuration word.
  function automatic logic [FIELD_W-1:0] field_at(input logic [CFG_W-1:0] w,
                                                   input int lsb);
    return w[lsb +: FIELD_W];
  endfunction

  // Phase entered once select has been released.
  function automatic phase_t phase_after_release(input logic [FIELD_W-1:0] gap);
    return (gap != '0) ? PH_GAP : PH_IDLE;
  endfunction

  // Phases in which the select line is driven low.
  function automatic logic drives_select(input phase_t p);
    return (p == PH_SETUP) || (p == PH_ACTIVE) || (p == PH_HOLD);
  endfunction

endpackage

// File: rtl/csel_tail_capture.sv
module csel_tail_capture
  import csel_seq_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [FW-1:0] hold_in,
  input  logic [FW-1:0] gap_in,
  output tail_t         tail
);

  // Hold and gap are needed after the accept cycle, so they are latched.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail <= '0;
    end else if (capture) begin
      tail.hold <= hold_in;
      tail.gap  <= gap_in;
    end
  end

endmodule

// File: rtl/csel_phase_timer.sv
module csel_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             at_zero,
  output logic             at_one
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign at_zero = (cnt == '0);
  assign at_one  = (cnt == CNT_W'(1));

endmodule

// File: rtl/csel_timing_seq.sv
module csel_timing_seq
  import csel_seq_pkg::*;
#(
  parameter int CFG_WIDTH = CFG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_WIDTH-1:0] cfg_word,
  input  logic                 req,
  input  logic                 last_bit_done,
  output logic                 busy,
  output logic                 sel_n,
  output logic                 xfer_start
);

  localparam int FW = FIELD_W;

  phase_t          phase_q, phase_d;
  tail_t           tail;
  logic [FW-1:0]   setup_live, hold_live, gap_live;
  logic            cfg_unused_spare;
  logic            t_load, t_dec, t_zero, t_one;
  logic [FW-1:0]   t_val;

  // Named internal events (observed by the bound checker).
  logic ev_accept, ev_start, ev_last, ev_release;

  assign setup_live       = field_at(cfg_word, SETUP_LSB);
  assign hold_live        = field_at(cfg_word, HOLD_LSB);
  assign gap_live         = field_at(cfg_word, GAP_LSB);
  assign cfg_unused_spare = ^cfg_word[SPARE_LSB +: SPARE_W];

  assign ev_accept  = (phase_q == PH_IDLE)   && req;
  assign ev_start   = (phase_q == PH_SETUP)  && t_zero;
  assign ev_last    = (phase_q == PH_ACTIVE) && last_bit_done;
  assign ev_release = ((phase_q == PH_HOLD) && t_one) ||
                      (ev_last && (tail.hold == '0));

  csel_tail_capture #(.FW(FW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (ev_accept),
    .hold_in (hold_live),
    .gap_in  (gap_live),
    .tail    (tail)
  );

  csel_phase_timer #(.CNT_W(FW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .at_zero  (t_zero),
    .at_one   (t_one)
  );

  always_comb begin
    phase_d = phase_q;
    t_load  = 1'b0;
    t_val   = '0;
    t_dec   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req) begin
          phase_d = PH_SETUP;
          t_load  = 1'b1;
          t_val   = setup_live;
        end
      end
      PH_SETUP: begin
        if (t_zero) phase_d = PH_ACTIVE;
        else        t_dec   = 1'b1;
      end
      PH_ACTIVE: begin
        if (last_bit_done) begin
          t_load = 1'b1;
          if (tail.hold != '0) begin
            phase_d = PH_HOLD;
            t_val   = tail.hold;
          end else begin
            phase_d = phase_after_release(tail.gap);
            t_val   = tail.gap;
          end
        end
      end
      PH_HOLD: begin
        if (t_one) begin
          phase_d = phase_after_release(tail.gap);
          t_load  = 1'b1;
          t_val   = tail.gap;
        end else begin
          t_dec = 1'b1;
        end
      end
      PH_GAP: begin
        if (t_one) phase_d = PH_IDLE;
        else       t_dec   = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign sel_n      = !drives_select(phase_q);
  assign busy       = (phase_q != PH_IDLE);
  assign xfer_start = ev_start;

endmodule

// File: rtl/csel_timing_chk.sv
module csel_timing_chk
  import csel_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_word,
  input logic             busy,
  input logic             sel_n,
  input logic             xfer_start,
  input logic             ev_accept,
  input logic             ev_last
);

  localparam int SW = FIELD_W + 1;
  localparam logic [SW-1:0] SAT = '1;

  logic [FIELD_W-1:0] setup_cap, hold_cap, gap_cap;
  logic [SW-1:0]      su_cnt, ho_cnt, hi_cnt;
  logic               seen;
  logic               chk_unused_spare;

  assign chk_unused_spare = ^cfg_word[SPARE_LSB +: SPARE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_cap <= '0;
      hold_cap  <= '0;
      gap_cap   <= '0;
      su_cnt    <= '0;
      ho_cnt    <= '0;
      hi_cnt    <= '0;
      seen      <= 1'b0;
    end else begin
      if (ev_accept) begin
        setup_cap <= cfg_word[SETUP_LSB +: FIELD_W];
        hold_cap  <= cfg_word[HOLD_LSB  +: FIELD_W];
        gap_cap   <= cfg_word[GAP_LSB   +: FIELD_W];
        seen      <= 1'b1;
      end
      su_cnt <= ev_accept ? '0 : ((su_cnt == SAT) ? su_cnt : su_cnt + SW'(1));
      ho_cnt <= ev_last   ? '0 : ((ho_cnt == SAT) ? ho_cnt : ho_cnt + SW'(1));
      hi_cnt <= !sel_n    ? '0 : ((hi_cnt == SAT) ? hi_cnt : hi_cnt + SW'(1));
    end
  end

  // R1: start lands setup cycles into the low select window
  a_r1_setup_span: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (su_cnt == {1'b0, setup_cap}));

  // R2: select rises hold+1 cycles after the last bit
  a_r2_hold_span: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> (ho_cnt == {1'b0, hold_cap}));

  // R3: the gap is honoured before the next accept
  a_r3_gap_span: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && seen) |-> (hi_cnt >= {1'b0, gap_cap}));

  // R4: start pulse is a single cycle
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  // R4: start only inside the select window
  a_r4_start_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !sel_n);

  // R5: an asserted select implies busy
  a_r5_select_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> busy);

  // R9: a last-bit event counts only inside the select window
  a_r9_last_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |-> !sel_n);

endmodule

bind csel_timing_seq csel_timing_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_word   (cfg_word),
  .busy       (busy),
  .sel_n      (sel_n),
  .xfer_start (xfer_start),
  .ev_accept  (ev_accept),
  .ev_last    (ev_last)
);

// File: tb/sim_csel_timing_seq.sv
module sim_csel_timing_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        req = 1'b0;
  logic        last_bit_done = 1'b0;
  logic        busy, sel_n, xfer_start;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // 250 MHz: 4 time units per period
  always #2 clk = ~clk;

  csel_timing_seq u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_word      (cfg_word),
    .req           (req),
    .last_bit_done (last_bit_done),
    .busy          (busy),
    .sel_n         (sel_n),
    .xfer_start    (xfer_start)
  );

  // Cycle index and edge monitor
  int cyc = 0;
  int n_fall = 0, n_rise = 0, n_start = 0, n_wide = 0;
  int t_fall = 0, t_rise = 0, t_start = 0;
  logic prev_sel = 1'b1, prev_start = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_sel && !sel_n) begin n_fall++; t_fall = cyc; end
      if (!prev_sel && sel_n) begin n_rise++; t_rise = cyc; end
      if (xfer_start) begin
        n_start++; t_start = cyc;
        if (prev_start) n_wide++;
      end
    end
    prev_sel   = sel_n;
    prev_start = xfer_start;
  end

  function automatic logic [31:0] mk(input int s, input int h, input int g, input int m);
    return {g[7:0], m[7:0], h[7:0], s[7:0]};
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic settle;
    @(negedge clk); #1;
  endtask

  // One transaction. armed: req/cfg already set by the previous call.
  task automatic run_txn(input logic [31:0] cfg, input int act, input bit armed,
                         input bit chain, input logic [31:0] nxt, input bit spur,
                         input int exp_gap, input string tag);
    int f0, s0, r0, su, ho, ga, tl;
    su = int'(cfg[7:0]); ho = int'(cfg[15:8]); ga = int'(cfg[31:24]);
    f0 = n_fall; s0 = n_start; r0 = n_rise;
    if (!armed) begin @(posedge clk); #1; cfg_word = cfg; req = 1'b1; end
    do settle(); while (n_fall == f0);
    if (exp_gap >= 0)
      chk(t_fall - t_rise == exp_gap, {"R3 high gap ", tag}, t_fall - t_rise, exp_gap);
    @(posedge clk); #1;
    req = 1'b0;
    cfg_word = ~cfg;                    // R7: rewrite after accept
    if (spur) begin
      last_bit_done = 1'b1;             // R9: pulse during setup
      @(posedge clk); #1;
      last_bit_done = 1'b0;
    end
    while (n_start == s0) settle();
    chk(t_start - t_fall == su, {"R1 R7 setup ", tag}, t_start - t_fall, su);
    chk(!sel_n, {"R9 select held after spurious last ", tag}, int'(sel_n), 0);
    repeat (act) @(posedge clk);
    #1; last_bit_done = 1'b1; tl = cyc;
    @(posedge clk); #1; last_bit_done = 1'b0;
    if (chain) begin cfg_word = nxt; req = 1'b1; end
    while (n_rise == r0) settle();
    chk(t_rise - tl == ho + 1, {"R2 R7 hold ", tag}, t_rise - tl, ho + 1);
    chk(n_start - s0 == 1, {"R4 one start ", tag}, n_start - s0, 1);
    if (chain && ga > 0)
      chk(busy && sel_n, {"R6 held off in gap ", tag}, int'(busy), 1);
  endtask

  task automatic idle_after(input int gap, input string tag);
    repeat (gap + 2) @(posedge clk);
    settle();
    chk(!busy, {"R6 idle after gap ", tag}, int'(busy), 0);
    chk(sel_n, {"R5 select idle high ", tag}, int'(sel_n), 1);
  endtask

  task automatic t_reset;
    settle();
    chk(sel_n == 1'b1, "R5 reset sel_n", int'(sel_n), 1);
    chk(busy == 1'b0, "R5 reset busy", int'(busy), 0);
    chk(xfer_start == 1'b0, "R4 reset start", int'(xfer_start), 0);
  endtask

  task automatic t_typical;
    run_txn(mk(4, 4, 36, 0), 3, 0, 0, '0, 0, -1, "typical");
    idle_after(36, "typical");
  endtask

  task automatic t_zero;
    run_txn(mk(0, 0, 0, 0), 1, 0, 0, '0, 0, -1, "zero");
    idle_after(0, "zero");
  endtask

  task automatic t_chain;
    logic [31:0] a, b, c;
    a = mk(2, 3, 5, 0); b = mk(1, 0, 0, 0); c = mk(3, 1, 2, 0);
    run_txn(a, 2, 0, 1, b, 0, -1, "chainA");
    run_txn(b, 1, 1, 1, c, 0, 6, "chainB");
    run_txn(c, 4, 1, 0, '0, 0, 1, "chainC");
    idle_after(2, "chainC");
  endtask

  task automatic t_spare_bits;
    logic [31:0] a, b;
    a = mk(2, 2, 3, 8'hFF); b = mk(1, 5, 1, 8'hA5);
    run_txn(a, 2, 0, 1, b, 0, -1, "R8 spare=FF");
    run_txn(b, 1, 1, 0, '0, 0, 4, "R8 spare=A5");
    idle_after(1, "R8");
  endtask

  task automatic t_spurious;
    run_txn(mk(3, 2, 1, 0), 2, 0, 0, '0, 1, -1, "R9 spurious");
    idle_after(1, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    t_reset();
    t_typical();
    t_zero();
    t_chain();
    t_spare_bits();
    t_spurious();
    chk(n_wide == 0, "R4 start width", n_wide, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule